// File: doc/BRIEF.md
# Programmable Video Line Delay

This block holds back a stream of 12-bit video samples by a programmable number of clock cycles, so that one line of picture can be lined up with the next. On every rising clock edge it takes one input word and presents one output word. No handshake and no back-pressure exist: the stream advances on every clock, and the upstream source must supply a word each cycle.

The delay is set by an 11-bit length code. The delay in clocks is the code plus a fixed offset of 31, which gives a range of 31 to 2078. The code is taken into the block only while reset is held low, and on the first edge after reset is released. After that, changes on the code pins have no effect until the next reset. Storage is a ring of memory words with one wrapping pointer, and registers sit on both sides of the memory so that the whole datapath is registered.

An output-enable input stands in for pad-level tristate control. When it is high, the block drives the delayed word and raises a drive flag. When it is low, the data lines read zero and the flag is low, which marks the high-impedance state. The enable never touches the contents of the delay line.

Top module: `vline_delay`

## Requirements
- R1: Input and output words are 12 bits wide. Every one of the 12 bits passes through unchanged, and one word enters and one word leaves on every rising clock edge.
- R2: With length code C taken as an unsigned 11-bit number, the delay is LH = 31 + C. The word sampled on `in_data` at rising edge k appears on `out_data` right after rising edge k + LH.
- R3: Code 0 gives a delay of exactly 31 clocks and code 2047 gives exactly 2078 clocks. The ring pointer stays within the programmed length and returns to zero after its last position.
- R4: The length code is sampled on every edge while `rst_n` is low and on the first edge after `rst_n` goes high. A code applied at the same time as the release takes effect. A code changed later leaves the running delay unchanged.
- R5: While `rst_n` is low, `out_data` reads all zeros.
- R6: When `oe` is 1, `out_drive` is 1 and `out_data` carries the delayed word. When `oe` is 0, `out_drive` is 0 (high-impedance) and `out_data` reads zero. Toggling `oe` does not disturb the words still in the delay line.
- R7: Asserting reset again, even with words in flight, restarts the line with the newly presented code. From then on the new delay applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Delay clock; all storage advances on its rising edge |
| rst_n | input | 1 | Active-low reset; clears pointer and output stage, opens the length capture |
| in_data | input | 12 | Sample word entering the line, one per clock |
| len_code | input | 11 | Length code; delay = 31 + code |
| oe | input | 1 | Output enable; 1 drives data, 0 selects high-impedance |
| out_data | output | 12 | Delayed sample word, zero when not driven |
| out_drive | output | 1 | 1 when the outputs are driven, 0 for high-impedance |

## Verification
Two events can land on the same edge: the length capture and the first pointer step after reset is released. The bench provokes this by holding one code during reset and presenting a different code in the same cycle that `rst_n` rises. It then judges the result by comparing every output word, against a reference stream computed from the sample index, with the delay of the second code. A second overlap, an enable drop while delayed words are leaving the ring, is judged by checking zeros during the gap and exact data right after it.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam int unsigned VLD_DATA_W = 12;
  localparam int unsigned VLD_CODE_W = 11;
  localparam int unsigned VLD_OFFSET = 31;
  // registers outside the ring: input capture and output stage
  localparam int unsigned VLD_PIPE   = 2;

  // ring words needed for the longest delay
  function automatic int unsigned vld_ring_depth(input int unsigned code_w,
                                                 input int unsigned offset);
    return (1 << code_w) - 1 + offset - VLD_PIPE;
  endfunction
endpackage

// File: rtl/vld_len_ctl.sv
module vld_len_ctl #(
  parameter int unsigned CODE_W = 11,
  parameter int unsigned OFFSET = 31,
  parameter int unsigned PTR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] len_code,
  output logic              run_flag,
  output logic [PTR_W-1:0]  ring_last
);
  import vld_pkg::*;

  localparam logic [PTR_W-1:0] LAST_BIAS = PTR_W'(OFFSET - VLD_PIPE - 1);

  logic             run_q;
  logic [PTR_W-1:0] last_q;

  // run_q stays low through reset and the release edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  // last ring index = code + offset - pipeline - 1, frozen while running
  always_ff @(posedge clk) begin
    if (!run_q) last_q <= PTR_W'(len_code) + LAST_BIAS;
  end

  assign run_flag  = run_q;
  assign ring_last = last_q;
endmodule

// File: rtl/vld_ring.sv
module vld_ring #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 2076,
  parameter int unsigned PTR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  ring_last,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [PTR_W-1:0]  ptr_q;

  // single pointer: read the oldest word, overwrite it with the newest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr_q <= '0;
    else if (ptr_q == ring_last) ptr_q <= '0;
    else                         ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    mem[ptr_q] <= wr_data;
    rd_q       <= mem[ptr_q];
  end

  assign rd_data = rd_q;
  assign ptr     = ptr_q;
endmodule

// File: rtl/vld_out_stage.sv
module vld_out_stage #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              oe,
  output logic [DATA_W-1:0] out_data,
  output logic              out_drive
);
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= rd_data;
  end

  // enable only gates the pins; the register keeps running
  assign out_data  = oe ? out_q : '0;
  assign out_drive = oe;
endmodule

// File: rtl/vline_delay.sv
module vline_delay #(
  parameter int unsigned DATA_W = vld_pkg::VLD_DATA_W,
  parameter int unsigned CODE_W = vld_pkg::VLD_CODE_W,
  parameter int unsigned OFFSET = vld_pkg::VLD_OFFSET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CODE_W-1:0] len_code,
  input  logic              oe,
  output logic [DATA_W-1:0] out_data,
  output logic              out_drive
);
  import vld_pkg::*;

  localparam int unsigned DEPTH = vld_ring_depth(CODE_W, OFFSET);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] cap_q;
  logic              run_flag;
  logic [PTR_W-1:0]  ring_last;
  logic [PTR_W-1:0]  ring_ptr;
  logic [DATA_W-1:0] ring_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= in_data;
  end

  vld_len_ctl #(.CODE_W(CODE_W), .OFFSET(OFFSET), .PTR_W(PTR_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_code (len_code),
    .run_flag (run_flag),
    .ring_last(ring_last)
  );

  vld_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (cap_q),
    .ring_last(ring_last),
    .rd_data  (ring_rd),
    .ptr      (ring_ptr)
  );

  vld_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (ring_rd),
    .oe       (oe),
    .out_data (out_data),
    .out_drive(out_drive)
  );
endmodule

// File: rtl/vline_delay_chk.sv
module vline_delay_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PTR_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic [DATA_W-1:0] out_data,
  input logic              run_flag,
  input logic [PTR_W-1:0]  ring_last,
  input logic [PTR_W-1:0]  ring_ptr,
  input logic [DATA_W-1:0] ring_rd
);
  // R4: captured length stays put once running
  p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_flag && $past(run_flag) |-> $stable(ring_last));

  // R3: pointer never passes the programmed last index
  p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_flag |-> ring_ptr <= ring_last);

  // R3: pointer returns to zero after its last position
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_flag && (ring_ptr == ring_last) |=> ring_ptr == '0);

  // R2: driven output is the ring word one stage later
  p_out_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_flag && oe |-> out_data == $past(ring_rd));

  // R5: outputs read zero during reset
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      p_reset_clear_r5: assert (out_data == '0);
    end
  end
endmodule

bind vline_delay vline_delay_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_vline_delay_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe       (oe),
  .out_data (out_data),
  .run_flag (run_flag),
  .ring_last(ring_last),
  .ring_ptr (ring_ptr),
  .ring_rd  (ring_rd)
);

// File: tb/test_vline_delay.sv
`timescale 1ns/1ps
module test_vline_delay;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] in_data;
  logic [10:0] len_code;
  logic        oe;
  logic [11:0] out_data;
  logic        out_drive;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  vline_delay i_vline_delay (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .len_code(len_code),
    .oe(oe), .out_data(out_data), .out_drive(out_drive)
  );

  // odd multiplier: distinct 12-bit word for each index, all bits toggle
  function automatic logic [11:0] pat(input int j, input int seed);
    return 12'((j * 1237) + (seed * 311));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int code);
    rst_n    = 1'b0;
    oe       = 1'b1;
    in_data  = '0;
    len_code = 11'(code);
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // release reset with code_rel, change code to code_late later, check every output
  task automatic run_stream(input int code_rel, input int code_late, input int extra,
                            input int seed, input bit oe_gap, input string req);
    int lh;
    lh       = 31 + code_rel;
    len_code = 11'(code_rel);
    rst_n    = 1'b1;
    in_data  = pat(0, seed);
    for (int j = 0; j < lh + extra; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (j == 3) len_code = 11'(code_late);
      oe = !(oe_gap && j >= lh + 4 && j < lh + 8);
      #1;
      if (j >= lh) begin
        if (oe) begin
          check(req, "drive flag", int'(out_drive), 1);
          check(req, "delayed word", int'(out_data), int'(pat(j - lh, seed)));
        end else begin
          check(req, "hiz flag", int'(out_drive), 0);
          check(req, "hiz data", int'(out_data), 0);
        end
      end
      in_data = pat(j + 1, seed);
    end
    oe = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(0);
    check("R5", "reset data", int'(out_data), 0);
    check("R6", "reset drive on", int'(out_drive), 1);
    oe = 1'b0;
    #1;
    check("R6", "reset drive off", int'(out_drive), 0);
    oe = 1'b1;
  endtask

  task automatic t_min_length;
    do_reset(0);
    run_stream(0, 0, 80, 1, 1'b0, "R3");
  endtask

  task automatic t_max_length;
    do_reset(2047);
    run_stream(2047, 2047, 60, 2, 1'b0, "R3");
  endtask

  task automatic t_mid_lengths;
    do_reset(500);
    run_stream(500, 500, 50, 3, 1'b0, "R2");
    do_reset(1);
    run_stream(1, 1, 70, 4, 1'b0, "R1");
  endtask

  task automatic t_code_frozen;
    do_reset(100);
    run_stream(100, 3, 120, 5, 1'b0, "R4");
  endtask

  task automatic t_release_edge;
    // code 10 held in reset, code 40 presented on the release cycle
    do_reset(10);
    run_stream(40, 40, 60, 6, 1'b0, "R4");
  endtask

  task automatic t_oe_gap;
    do_reset(20);
    run_stream(20, 20, 40, 7, 1'b1, "R6");
  endtask

  task automatic t_rereset;
    do_reset(300);
    run_stream(300, 300, 10, 8, 1'b0, "R7");
    do_reset(7);
    run_stream(7, 7, 60, 9, 1'b0, "R7");
  endtask

  initial begin
    rst_n    = 1'b0;
    oe       = 1'b1;
    in_data  = '0;
    len_code = '0;
    t_reset_state();
    t_min_length();
    t_max_length();
    t_mid_lengths();
    t_code_frozen();
    t_release_edge();
    t_oe_gap();
    t_rereset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule